// File: doc/BRIEF.md
# Flash Block Protection Unit

This block guards the top of a 64 KB flash address map against accidental program and erase operations. It holds an 8-bit protection setting. Bits 7:1 form a 7-bit select field and bit 0 is a disable bit. The select field, with nine 1 bits appended below it, gives the last address that may still be modified. Every address above that value, up to 0xFFFF, is protected. The protected region therefore always starts on a 512-byte boundary.

After reset the setting is taken from a nonvolatile protection byte presented on an input. Application software cannot change the setting: its write port is accepted and then dropped. The debug write port can replace the setting, which is how protected flash is erased and reprogrammed.

Each launch request carries a command code and an address. The unit raises a violation strobe in the same cycle when the command must be refused. A mass erase is refused whenever protection is active, because the protection byte sits inside the last 512 bytes.

Top module: `fprot_unit`

## Requirements
- R1: While reset is asserted, and until the nonvolatile byte has been loaded, `prot_setting` reads 0x00. This value protects everything above 0x01FF.
- R2: The reset is released synchronously through two flops. On the third rising clock edge after `rst_n` rises, `prot_setting` takes the value of `nv_prot_byte`. A debug write presented in that loading cycle is dropped.
- R3: A write on the application port never changes `prot_setting`.
- R4: Outside the loading cycle, a debug write sets `prot_setting` to `dbg_wr_data` at the next rising edge.
- R5: When bit 0 of `prot_setting` is 1, protection is disabled and `violation` stays low for every command and address.
- R6: Command codes 1 (byte program), 2 (burst program) and 3 (page erase) raise `violation` when protection is active and `req_addr` is greater than {`prot_setting`[7:1], nine 1 bits}. At or below that address they do not.
- R7: Command code 4 (mass erase) raises `violation` whenever bit 0 of `prot_setting` is 0, whatever the address.
- R8: Command code 0 (blank check) and codes 5 to 7 never raise `violation`.
- R9: `violation` is high only in a cycle where `req_valid` is high. It is combinational, so it appears in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_prot_byte | input | 8 | Nonvolatile protection byte, loaded after reset |
| dbg_wr_en | input | 1 | Debug write strobe |
| dbg_wr_data | input | 8 | Debug write value |
| app_wr_en | input | 1 | Application write strobe (ignored) |
| app_wr_data | input | 8 | Application write value (ignored) |
| req_valid | input | 1 | Command launch request |
| req_cmd | input | 3 | Command code |
| req_addr | input | 16 | Target address of the command |
| prot_setting | output | 8 | Current protection setting |
| violation | output | 1 | Request refused by protection |

## Verification
The compare is tried with addresses that sit exactly on the boundary and one above it, and with 0xFFFF. This separates a greater-than compare from a greater-or-equal compare, and exposes a wrong count of appended 1 bits. Three settings are used: 0xF8 gives a mid boundary, 0xFE gives a boundary of 0xFFFF, and 0x00 gives a boundary of 0x01FF. Together they tell a correct bit concatenation apart from a shifted or truncated one. Each command code is sent with protection both enabled and disabled. This separates the address-range commands, mass erase and blank check from one another. An application write that differs from the current setting shows whether that port is really ignored. Debug writes show whether the register can be reloaded.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  localparam int ADDR_W = 16;
  localparam int SEL_W  = 7;
  localparam int SET_W  = SEL_W + 1;
  localparam int CMD_W  = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_BLANK = 3'd0,
    CMD_BYTE  = 3'd1,
    CMD_BURST = 3'd2,
    CMD_PAGE  = 3'd3,
    CMD_MASS  = 3'd4
  } fcmd_e;
endpackage

// File: rtl/fprot_rst_sync.sv
module fprot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fprot_reg.sv
module fprot_reg #(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] nv_byte,
  input  logic             dbg_wr_en,
  input  logic [SET_W-1:0] dbg_wr_data,
  output logic [SET_W-1:0] setting
);
  logic             load_q, load_d;
  logic [SET_W-1:0] setting_q, setting_d;
  logic             setting_en;

  always_comb begin
    load_d     = 1'b0;
    setting_d  = setting_q;
    setting_en = 1'b0;
    if (load_q) begin
      setting_d  = nv_byte;
      setting_en = 1'b1;
    end else if (dbg_wr_en) begin
      setting_d  = dbg_wr_data;
      setting_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b1;
    else        load_q <= load_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          setting_q <= '0;
    else if (setting_en) setting_q <= setting_d;
  end

  assign setting = setting_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> (setting == $past(nv_byte)));

  assert_dbg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_q && dbg_wr_en) |=> (setting == $past(dbg_wr_data)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_q && !dbg_wr_en) |=> $stable(setting));
endmodule

// File: rtl/fprot_cmp.sv
module fprot_cmp
  import fprot_pkg::*;
#(
  parameter int A_W = 16,
  parameter int S_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [S_W:0]   setting,
  input  logic           req_valid,
  input  logic [CMD_W-1:0] req_cmd,
  input  logic [A_W-1:0] req_addr,
  output logic           violation
);
  localparam int BLK_W = A_W - S_W;

  logic [A_W-1:0] last_open;
  logic           prot_on, range_cmd, mass_cmd, above;
  fcmd_e          cmd;

  assign cmd       = fcmd_e'(req_cmd);
  assign last_open = {setting[S_W:1], {BLK_W{1'b1}}};
  assign prot_on   = ~setting[0];
  assign above     = req_addr > last_open;

  always_comb begin
    range_cmd = 1'b0;
    mass_cmd  = 1'b0;
    case (cmd)
      CMD_BYTE, CMD_BURST, CMD_PAGE: range_cmd = 1'b1;
      CMD_MASS:                      mass_cmd  = 1'b1;
      default: ;
    endcase
  end

  assign violation = req_valid & prot_on & ((range_cmd & above) | mass_cmd);

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    setting[0] |-> !violation);

  assert_mass_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'd4 && !setting[0]) |-> violation);

  assert_blank_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cmd == 3'd0 || req_cmd > 3'd4) |-> !violation);

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !violation);

  assert_low_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[A_W-1:BLK_W] < setting[S_W:1]) |-> (!violation || req_cmd == 3'd4));
endmodule

// File: rtl/fprot_unit.sv
module fprot_unit
  import fprot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  nv_prot_byte,
  input  logic              dbg_wr_en,
  input  logic [SET_W-1:0]  dbg_wr_data,
  input  logic              app_wr_en,
  input  logic [SET_W-1:0]  app_wr_data,
  input  logic              req_valid,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [SET_W-1:0]  prot_setting,
  output logic              violation
);
  logic rst_n_s;

  fprot_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fprot_reg #(.SET_W(SET_W)) u_reg (
    .clk(clk), .rst_n(rst_n_s), .nv_byte(nv_prot_byte),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
    .setting(prot_setting)
  );

  fprot_cmp #(.A_W(ADDR_W), .S_W(SEL_W)) u_cmp (
    .clk(clk), .rst_n(rst_n_s), .setting(prot_setting),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .violation(violation)
  );

  assert_app_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (app_wr_en && !dbg_wr_en && app_wr_data != prot_setting && $past(rst_n_s))
      |=> (prot_setting == $past(prot_setting)));
endmodule

// File: tb/sim_fprot_unit.sv
`timescale 1ns/1ps
module sim_fprot_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  nv_prot_byte;
  logic        dbg_wr_en;
  logic [7:0]  dbg_wr_data;
  logic        app_wr_en;
  logic [7:0]  app_wr_data;
  logic        req_valid;
  logic [2:0]  req_cmd;
  logic [15:0] req_addr;
  logic [7:0]  prot_setting;
  logic        violation;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fprot_unit u0 (
    .clk(clk), .rst_n(rst_n), .nv_prot_byte(nv_prot_byte),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_data(dbg_wr_data),
    .app_wr_en(app_wr_en), .app_wr_data(app_wr_data),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .prot_setting(prot_setting), .violation(violation)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] nv);
    @(negedge clk);
    rst_n = 1'b0; nv_prot_byte = nv;
    dbg_wr_en = 0; dbg_wr_data = 0; app_wr_en = 0; app_wr_data = 0;
    req_valid = 0; req_cmd = 0; req_addr = 0;
    @(negedge clk);
    check("R1 reset value", {8'h0, prot_setting}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 before load", {8'h0, prot_setting}, 16'h0000);
    @(negedge clk);
    check("R2 nv load", {8'h0, prot_setting}, {8'h0, nv});
  endtask

  task automatic request(input string req, input logic [2:0] cmd, input logic [15:0] addr,
                         input logic exp);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr;
    #1;
    check(req, {15'h0, violation}, {15'h0, exp});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic dbg_write(input logic [7:0] v);
    @(negedge clk);
    dbg_wr_en = 1'b1; dbg_wr_data = v;
    @(negedge clk);
    dbg_wr_en = 1'b0;
    check("R4 debug write", {8'h0, prot_setting}, {8'h0, v});
  endtask

  task automatic t_boundary;
    request("R6 byte at last open", 3'd1, 16'hF9FF, 1'b0);
    request("R6 byte above", 3'd1, 16'hFA00, 1'b1);
    request("R6 byte top", 3'd1, 16'hFFFF, 1'b1);
    request("R6 burst above", 3'd2, 16'hFA00, 1'b1);
    request("R6 page low", 3'd3, 16'h1000, 1'b0);
    request("R6 page above", 3'd3, 16'hFC00, 1'b1);
    request("R7 mass active", 3'd4, 16'h0000, 1'b1);
    request("R8 blank top", 3'd0, 16'hFFFF, 1'b0);
    request("R8 code 6", 3'd6, 16'hFFFF, 1'b0);
    @(negedge clk);
    req_valid = 1'b0; req_cmd = 3'd1; req_addr = 16'hFFFF;
    #1;
    check("R9 no request", {15'h0, violation}, 16'h0000);
  endtask

  task automatic t_app_ignored;
    @(negedge clk);
    app_wr_en = 1'b1; app_wr_data = 8'h01;
    @(negedge clk);
    app_wr_en = 1'b0;
    @(negedge clk);
    check("R3 app write ignored", {8'h0, prot_setting}, 16'h00F8);
  endtask

  task automatic t_debug;
    dbg_write(8'h01);
    request("R5 disabled byte", 3'd1, 16'hFFFF, 1'b0);
    request("R5 disabled mass", 3'd4, 16'h0000, 1'b0);
    dbg_write(8'hFE);
    request("R6 full-top boundary", 3'd1, 16'hFFFF, 1'b0);
    request("R7 mass with empty region", 3'd4, 16'h0000, 1'b1);
    dbg_write(8'h00);
    request("R6 lowest boundary", 3'd3, 16'h01FF, 1'b0);
    request("R6 above lowest", 3'd3, 16'h0200, 1'b1);
  endtask

  task automatic t_load_drop;
    @(negedge clk);
    rst_n = 1'b0; nv_prot_byte = 8'h81;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    dbg_wr_en = 1'b1; dbg_wr_data = 8'h44;
    @(negedge clk);
    dbg_wr_en = 1'b0;
    check("R2 load beats debug", {8'h0, prot_setting}, 16'h0081);
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset(8'hF8);
    t_boundary();
    t_app_ignored();
    t_debug();
    t_load_drop();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule